// File: doc/BRIEF.md
# Capability-Checked Read Gate

This block sits in front of every read-side access into a 32-bit flat address space that holds ordinary memory, attached devices and the machine register bank. A requester presents an access: an address, a byte length, an operation kind and a machine-elevation flag. With it come a capability token, the current version of the target object, a seal-valid verdict from an external MAC unit and the requesting thread's ID. The block works out the segment from the address's top byte. It then runs one fixed, ordered chain of checks: permission, bounds, version and seal. The chain is the same for all three segments.

When every check passes, the block emits the token with its G bit cleared, pulses a destination-register write enable, and latches the cleared token into a per-thread shadow slot. When a check fails, the block pulses a fault and reports a cause code for the first step that failed. Nothing from a failing request reaches the grant outputs, the write enable or the shadow. The cause is held, and new requests are refused, until the requester acknowledges the fault.

The token is a flat 79-bit vector with this layout:
- bits [5:0]: permissions
- bits [29:6]: base
- bits [53:30]: limit
- bits [61:54]: version
- bit [62]: G
- bits [78:63]: seal

Top module: `cap_gate`

## Requirements
- R1: The segment is taken from `req_addr[31:24]`. Values 0x00 to 0xFD select memory (`grant_seg`=0). 0xFE selects devices (1). 0xFF selects the register bank (2). The segment is reported on `grant_seg` with each grant.
- R2: Operation codes 0 to 5 each require token permission bit 0 to 5 respectively: 0 data read, 1 data write, 2 lambda entry, 3 capability load, 4 capability save, 5 call entry. If that bit is clear, or the code is 6 or 7, the request faults with cause 1.
- R3: Device-segment and memory-segment requests always go through the permission check, whatever the state of `req_elev`.
- R4: A register-segment request with `req_elev`=1 skips the permission check. With `req_elev`=0 it is checked like any other request.
- R5: With offset = `req_addr[23:0]`, the bounds check passes only when all of these hold: `req_len` ≠ 0, offset ≥ base, and offset+len−1 ≤ limit. The sum is computed without truncation to 24 bits. Otherwise the request faults with cause 2.
- R6: If the token version differs from `req_obj_ver`, the request faults with cause 3.
- R7: If `req_seal_ok` is 0, the request faults with cause 4.
- R8: When several checks fail, the cause is that of the earliest step in the order permission, bounds, version, seal.
- R9: A request is accepted at a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is low in the following cycle. Exactly one of `res_done` and `res_fault` is then high for the single cycle that follows the next edge. After reset, both are 0.
- R10: On a grant, `grant_tok` equals the presented token with bit 62 cleared, and `rf_we` pulses together with `res_done`. On a fault, `rf_we` stays 0.
- R11: On a grant, shadow slot `req_tid` takes the cleared token. `shd_tok` shows slot `shd_tid` combinationally. A faulting request leaves every slot unchanged. Slots reset to 0.
- R12: After a fault, `res_cause` holds the code and `req_ready` stays 0 until `fault_ack` is sampled high at an edge. `res_cause` then returns to 0 and requests are accepted again. After reset, `req_ready`=1 and `res_cause`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Gate can accept a request |
| req_addr | input | 32 | Target address |
| req_len | input | 16 | Access length in bytes |
| req_op | input | 3 | Operation kind |
| req_elev | input | 1 | Machine-elevation flag |
| req_tok | input | 79 | Presented capability token |
| req_obj_ver | input | 8 | Current version of the target object |
| req_seal_ok | input | 1 | External seal verdict |
| req_tid | input | 2 | Requesting thread ID |
| res_done | output | 1 | One-cycle grant pulse |
| res_fault | output | 1 | One-cycle fault pulse |
| res_cause | output | 3 | Held fault cause (0 none, 1 perm, 2 bounds, 3 version, 4 seal) |
| fault_ack | input | 1 | Releases a held fault |
| grant_tok | output | 79 | Granted token with G cleared |
| grant_seg | output | 2 | Segment of the granted access |
| rf_we | output | 1 | Destination register write pulse |
| shd_tid | input | 2 | Shadow slot to observe |
| shd_tok | output | 79 | Contents of that shadow slot |

## Verification
Each operation code is tried twice: once with only its own permission bit set, which must grant, and once with every other bit set, which must fault. A swapped bit mapping cannot survive both. The elevation flag is tried on all three segments, so a bypass that leaks into memory or devices shows up as a wrong grant. Bounds are probed at the exact-fit edge, one byte below base, one byte past the limit, at zero length and with an offset-plus-length that wraps past 24 bits. Tokens that fail several checks at once confirm the cause ordering. A faulting thread's shadow slot is watched continuously, along with a request held on the port while a fault is pending, to show that nothing leaks before the acknowledge.

// File: rtl/cap_gate_pkg.sv
package cap_gate_pkg;
  localparam int PERM_W  = 6;
  localparam int OFF_W   = 24;
  localparam int VER_W   = 8;
  localparam int SEAL_W  = 16;
  localparam int LEN_W   = 16;
  localparam int OP_W    = 3;
  localparam int ADDR_W  = 32;
  localparam int BASE_LSB = PERM_W;
  localparam int LIM_LSB  = BASE_LSB + OFF_W;
  localparam int VER_LSB  = LIM_LSB + OFF_W;
  localparam int G_BIT    = VER_LSB + VER_W;
  localparam int SEAL_LSB = G_BIT + 1;
  localparam int TOK_W    = SEAL_LSB + SEAL_W;

  typedef enum logic [1:0] {SEG_MEM = 2'd0, SEG_DEV = 2'd1, SEG_REG = 2'd2} seg_e;
  typedef enum logic [2:0] {
    C_NONE = 3'd0, C_PERM = 3'd1, C_BOUND = 3'd2, C_VER = 3'd3, C_SEAL = 3'd4
  } cause_e;

  function automatic seg_e seg_of(input logic [7:0] top);
    if (top == 8'hFF)      return SEG_REG;
    else if (top == 8'hFE) return SEG_DEV;
    else                   return SEG_MEM;
  endfunction

  // true when the token grants the permission that op needs
  function automatic logic perm_has(input logic [PERM_W-1:0] perm, input logic [OP_W-1:0] op);
    logic r;
    r = 1'b0;
    for (int i = 0; i < PERM_W; i++)
      if (op == OP_W'(i)) r = perm[i];
    return r;
  endfunction

  // window [off, off+len-1] must lie inside [base, lim], with carry kept
  function automatic logic span_ok(input logic [OFF_W-1:0] off, input logic [LEN_W-1:0] len,
                                   input logic [OFF_W-1:0] base, input logic [OFF_W-1:0] lim);
    logic [OFF_W:0] last;
    last = {1'b0, off} + {{(OFF_W+1-LEN_W){1'b0}}, len} - (OFF_W+1)'(1);
    return (len != '0) && (off >= base) && !last[OFF_W] && (last[OFF_W-1:0] <= lim);
  endfunction
endpackage

// File: rtl/cap_check.sv
module cap_check
  import cap_gate_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [OP_W-1:0]   op,
  input  logic              elev,
  input  logic [TOK_W-1:0]  tok,
  input  logic [VER_W-1:0]  obj_ver,
  input  logic              seal_ok,
  output seg_e              seg,
  output cause_e            cause,
  output logic              perm_fail,
  output logic              bnd_fail,
  output logic              ver_fail,
  output logic              seal_fail,
  output logic [TOK_W-1:0]  tok_clr
);
  logic bypass;

  assign seg       = seg_of(addr[ADDR_W-1:ADDR_W-8]);
  assign bypass    = elev && (seg == SEG_REG);
  assign perm_fail = !bypass && !perm_has(tok[PERM_W-1:0], op);
  assign bnd_fail  = !span_ok(addr[OFF_W-1:0], len, tok[BASE_LSB +: OFF_W], tok[LIM_LSB +: OFF_W]);
  assign ver_fail  = tok[VER_LSB +: VER_W] != obj_ver;
  assign seal_fail = !seal_ok;

  always_comb begin
    if (perm_fail)      cause = C_PERM;
    else if (bnd_fail)  cause = C_BOUND;
    else if (ver_fail)  cause = C_VER;
    else if (seal_fail) cause = C_SEAL;
    else                cause = C_NONE;
  end

  always_comb begin
    tok_clr = tok;
    tok_clr[G_BIT] = 1'b0;
  end
endmodule

// File: rtl/cap_shadow.sv
module cap_shadow #(
  parameter int NTHR  = 4,
  parameter int TID_W = 2,
  parameter int W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [TID_W-1:0] wtid,
  input  logic [W-1:0]     wdata,
  input  logic [TID_W-1:0] rtid,
  output logic [W-1:0]     rdata
);
  logic [W-1:0] slot [NTHR];

  for (genvar g = 0; g < NTHR; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              slot[g] <= '0;
      else if (we && (wtid == TID_W'(g)))      slot[g] <= wdata;
    end
  end

  assign rdata = (32'(rtid) < NTHR) ? slot[rtid] : '0;
endmodule

// File: rtl/cap_gate.sv
module cap_gate
  import cap_gate_pkg::*;
#(
  parameter  int NTHR  = 4,
  localparam int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [OP_W-1:0]   req_op,
  input  logic              req_elev,
  input  logic [TOK_W-1:0]  req_tok,
  input  logic [VER_W-1:0]  req_obj_ver,
  input  logic              req_seal_ok,
  input  logic [TID_W-1:0]  req_tid,
  output logic              res_done,
  output logic              res_fault,
  output logic [2:0]        res_cause,
  input  logic              fault_ack,
  output logic [TOK_W-1:0]  grant_tok,
  output logic [1:0]        grant_seg,
  output logic              rf_we,
  input  logic [TID_W-1:0]  shd_tid,
  output logic [TOK_W-1:0]  shd_tok
);
  logic              busy, pend;
  logic [ADDR_W-1:0] q_addr;
  logic [LEN_W-1:0]  q_len;
  logic [OP_W-1:0]   q_op;
  logic              q_elev, q_seal;
  logic [TOK_W-1:0]  q_tok;
  logic [VER_W-1:0]  q_ver;
  logic [TID_W-1:0]  q_tid;

  seg_e             chk_seg;
  cause_e           chk_cause;
  logic             perm_fail, bnd_fail, ver_fail, seal_fail;
  logic [TOK_W-1:0] chk_tok;
  logic             accept, pass, shd_we;

  cap_check u_chk (
    .addr(q_addr), .len(q_len), .op(q_op), .elev(q_elev), .tok(q_tok),
    .obj_ver(q_ver), .seal_ok(q_seal), .seg(chk_seg), .cause(chk_cause),
    .perm_fail(perm_fail), .bnd_fail(bnd_fail), .ver_fail(ver_fail),
    .seal_fail(seal_fail), .tok_clr(chk_tok)
  );

  assign req_ready = !busy && !pend;
  assign accept    = req_valid && req_ready;
  assign pass      = busy && (chk_cause == C_NONE);
  assign shd_we    = pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; pend <= 1'b0;
      res_done <= 1'b0; res_fault <= 1'b0; rf_we <= 1'b0;
      res_cause <= C_NONE; grant_tok <= '0; grant_seg <= SEG_MEM;
      q_addr <= '0; q_len <= '0; q_op <= '0; q_elev <= 1'b0;
      q_tok <= '0; q_ver <= '0; q_seal <= 1'b0; q_tid <= '0;
    end else begin
      res_done  <= 1'b0;
      res_fault <= 1'b0;
      rf_we     <= 1'b0;
      if (busy) begin
        busy <= 1'b0;
        if (pass) begin
          res_done  <= 1'b1;
          rf_we     <= 1'b1;
          grant_tok <= chk_tok;
          grant_seg <= chk_seg;
        end else begin
          res_fault <= 1'b1;
          pend      <= 1'b1;
          res_cause <= chk_cause;
        end
      end else if (pend) begin
        if (fault_ack) begin
          pend      <= 1'b0;
          res_cause <= C_NONE;
        end
      end else if (accept) begin
        busy   <= 1'b1;
        q_addr <= req_addr; q_len <= req_len; q_op <= req_op; q_elev <= req_elev;
        q_tok  <= req_tok;  q_ver <= req_obj_ver; q_seal <= req_seal_ok; q_tid <= req_tid;
      end
    end
  end

  cap_shadow #(.NTHR(NTHR), .TID_W(TID_W), .W(TOK_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .we(shd_we), .wtid(q_tid), .wdata(chk_tok),
    .rtid(shd_tid), .rdata(shd_tok)
  );

  p_one_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_done && res_fault));
  p_result_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done || res_fault) |-> $past(req_valid && req_ready, 2));
  p_cause_coded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_fault |-> (res_cause inside {3'd1, 3'd2, 3'd3, 3'd4}));
  p_cause_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !fault_ack) |=> ($stable(res_cause) && !req_ready));
  p_g_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> !grant_tok[G_BIT]);
  p_we_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);
  p_elev_reg_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && chk_seg != SEG_REG && !perm_has(q_tok[PERM_W-1:0], q_op)) |=> res_fault);
endmodule

// File: tb/cap_gate_tb.sv
module cap_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic [2:0]  req_op = '0;
  logic        req_elev = 1'b0;
  logic [78:0] req_tok = '0;
  logic [7:0]  req_obj_ver = '0;
  logic        req_seal_ok = 1'b0;
  logic [1:0]  req_tid = '0;
  logic        res_done, res_fault, rf_we;
  logic [2:0]  res_cause;
  logic        fault_ack = 1'b0;
  logic [78:0] grant_tok, shd_tok;
  logic [1:0]  grant_seg;
  logic [1:0]  shd_tid = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_gate u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_op(req_op), .req_elev(req_elev),
    .req_tok(req_tok), .req_obj_ver(req_obj_ver), .req_seal_ok(req_seal_ok),
    .req_tid(req_tid), .res_done(res_done), .res_fault(res_fault),
    .res_cause(res_cause), .fault_ack(fault_ack), .grant_tok(grant_tok),
    .grant_seg(grant_seg), .rf_we(rf_we), .shd_tid(shd_tid), .shd_tok(shd_tok)
  );

  int    vecs = 0, bad = 0, cyc = 0;
  bit    finished = 0;
  string cur_tag = "R9";

  // reference model state
  bit          m_busy, m_pend, m_done, m_fault;
  int          m_cause, m_seg;
  logic [78:0] m_tok;
  logic [78:0] m_shd [4];
  logic [31:0] l_addr; logic [15:0] l_len; logic [2:0] l_op; logic l_elev;
  logic [78:0] l_tok;  logic [7:0] l_ver;  logic l_seal; logic [1:0] l_tid;

  function automatic logic [78:0] mk(input logic [5:0] perm, input int base, input int lim,
                                     input logic [7:0] ver, input bit g, input logic [15:0] seal);
    return {seal, g, ver, lim[23:0], base[23:0], perm};
  endfunction

  function automatic int ref_cause(input logic [31:0] a, input logic [15:0] l, input logic [2:0] op,
                                   input bit el, input logic [78:0] tk, input logic [7:0] ov, input bit sk);
    int     top;
    bit     byp;
    longint off, base, lim, last;
    top = int'(a[31:24]);
    byp = el && (top == 255);
    if (!byp && !((op < 3'd6) && tk[op])) return 1;
    off  = longint'(a[23:0]);
    base = longint'(tk[29:6]);
    lim  = longint'(tk[53:30]);
    last = off + longint'(l) - 1;
    if (l == 0 || off < base || last > lim) return 2;
    if (tk[61:54] != ov) return 3;
    if (!sk) return 4;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_pend = 0; m_done = 0; m_fault = 0; m_cause = 0; m_seg = 0; m_tok = '0;
      for (int i = 0; i < 4; i++) m_shd[i] = '0;
    end else begin
      bit rdy;
      int c;
      rdy = !m_busy && !m_pend;
      m_done = 0; m_fault = 0;
      if (m_busy) begin
        m_busy = 0;
        c = ref_cause(l_addr, l_len, l_op, l_elev, l_tok, l_ver, l_seal);
        if (c == 0) begin
          m_done = 1;
          m_tok  = l_tok & ~(79'd1 << 62);
          m_seg  = (int'(l_addr[31:24]) <= 253) ? 0 : int'(l_addr[31:24]) - 253;
          m_shd[l_tid] = m_tok;
        end else begin
          m_fault = 1; m_pend = 1; m_cause = c;
        end
      end else if (m_pend) begin
        if (fault_ack) begin m_pend = 0; m_cause = 0; end
      end else if (req_valid && rdy) begin
        m_busy = 1;
        l_addr = req_addr; l_len = req_len; l_op = req_op; l_elev = req_elev;
        l_tok = req_tok; l_ver = req_obj_ver; l_seal = req_seal_ok; l_tid = req_tid;
      end
    end
  end

  always @(posedge clk) shd_tid <= shd_tid + 2'd1;

  task automatic chk(input string tag, input string what, input logic [127:0] act, input logic [127:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R12", "req_ready", 128'(req_ready), 128'(!m_busy && !m_pend));
      chk(cur_tag, "res_done", 128'(res_done), 128'(m_done));
      chk(cur_tag, "res_fault", 128'(res_fault), 128'(m_fault));
      chk(cur_tag, "res_cause", 128'(res_cause), 128'(m_cause));
      chk("R10", "rf_we", 128'(rf_we), 128'(m_done));
      if (m_done) begin
        chk("R1", "grant_seg", 128'(grant_seg), 128'(m_seg));
        chk("R10", "grant_tok", 128'(grant_tok), 128'(m_tok));
      end
      chk("R11", "shd_tok", 128'(shd_tok), 128'(m_shd[shd_tid]));
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !finished) begin
      bad++;
      $display("FAIL R9 watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  task automatic drive(input logic [31:0] a, input logic [15:0] l, input logic [2:0] op, input bit el,
                       input logic [78:0] tk, input logic [7:0] ov, input bit sk, input logic [1:0] tid);
    req_addr = a; req_len = l; req_op = op; req_elev = el;
    req_tok = tk; req_obj_ver = ov; req_seal_ok = sk; req_tid = tid;
  endtask

  task automatic issue(input string tag, input logic [31:0] a, input logic [15:0] l, input logic [2:0] op,
                       input bit el, input logic [78:0] tk, input logic [7:0] ov, input bit sk,
                       input logic [1:0] tid, input bit auto_ack = 1);
    @(negedge clk);
    cur_tag = tag;
    drive(a, l, op, el, tk, ov, sk, tid);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    if (auto_ack && m_pend) begin
      @(negedge clk);
      fault_ack = 1'b1;
      @(negedge clk);
      fault_ack = 1'b0;
    end
  endtask

  localparam logic [31:0] MEM = 32'h1200_0100;

  initial begin
    logic [78:0] full;
    full = mk(6'h3F, 0, 24'hFFFFFF, 8'h05, 1'b1, 16'hABCD);
    repeat (3) @(negedge clk);
    // reset state
    chk("R12", "reset req_ready", 128'(req_ready), 128'(1));
    chk("R9", "reset res_done", 128'(res_done), 128'(0));
    chk("R9", "reset res_fault", 128'(res_fault), 128'(0));
    chk("R12", "reset res_cause", 128'(res_cause), 128'(0));
    chk("R11", "reset shadow", 128'(shd_tok), 128'(0));
    rst_n = 1'b1;

    // basic grants per segment
    issue("R2", MEM, 16'd4, 3'd0, 0, mk(6'b000001, 0, 24'hFFFFFF, 8'h05, 1, 16'h1111), 8'h05, 1, 2'd1);
    issue("R1", 32'hFD00_0000, 16'd1, 3'd0, 0, full, 8'h05, 1, 2'd0);
    issue("R3", 32'hFE00_0010, 16'd2, 3'd1, 0, mk(6'b000010, 0, 24'hFFFFFF, 8'h05, 1, 16'h2222), 8'h05, 1, 2'd2);
    issue("R4", 32'hFF00_0020, 16'd4, 3'd0, 1, mk(6'b000000, 0, 24'hFFFFFF, 8'h05, 1, 16'h3333), 8'h05, 1, 2'd3);
    // elevation: register segment only
    issue("R4", 32'hFF00_0020, 16'd4, 3'd0, 0, mk(6'b000000, 0, 24'hFFFFFF, 8'h05, 1, 16'h3333), 8'h05, 1, 2'd3);
    issue("R3", MEM, 16'd4, 3'd0, 1, mk(6'b000000, 0, 24'hFFFFFF, 8'h05, 1, 16'h4444), 8'h05, 1, 2'd0);
    issue("R3", 32'hFE00_0000, 16'd4, 3'd3, 1, mk(6'b110111, 0, 24'hFFFFFF, 8'h05, 1, 16'h4444), 8'h05, 1, 2'd0);
    // op to permission mapping
    for (int op = 0; op < 6; op++) begin
      issue("R2", MEM, 16'd1, 3'(op), 0, mk(6'(1 << op), 0, 24'hFFFFFF, 8'h05, 1, 16'(op)), 8'h05, 1, 2'(op));
      issue("R2", MEM, 16'd1, 3'(op), 0, mk(~6'(1 << op), 0, 24'hFFFFFF, 8'h05, 1, 16'(op)), 8'h05, 1, 2'(op));
    end
    issue("R2", MEM, 16'd1, 3'd6, 0, full, 8'h05, 1, 2'd1);
    issue("R2", MEM, 16'd1, 3'd7, 1, full, 8'h05, 1, 2'd1);
    // bounds corners
    issue("R5", 32'h0000_00FF, 16'd1, 3'd0, 0, mk(6'h3F, 24'h100, 24'h1FF, 8'h05, 1, 16'h5), 8'h05, 1, 2'd2);
    issue("R5", 32'h0000_0100, 16'd1, 3'd0, 0, mk(6'h3F, 24'h100, 24'h100, 8'h05, 1, 16'h6), 8'h05, 1, 2'd2);
    issue("R5", 32'h0000_0100, 16'd2, 3'd0, 0, mk(6'h3F, 24'h100, 24'h100, 8'h05, 1, 16'h7), 8'h05, 1, 2'd2);
    issue("R5", 32'h00FF_FFF0, 16'h0020, 3'd0, 0, full, 8'h05, 1, 2'd2);
    issue("R5", 32'h00FF_FFF0, 16'h0010, 3'd0, 0, full, 8'h05, 1, 2'd2);
    issue("R5", MEM, 16'd0, 3'd0, 0, full, 8'h05, 1, 2'd2);
    // version and seal
    issue("R6", MEM, 16'd4, 3'd0, 0, full, 8'h06, 1, 2'd3);
    issue("R7", MEM, 16'd4, 3'd0, 0, full, 8'h05, 0, 2'd3);
    // priority among several failures
    issue("R8", MEM, 16'd0, 3'd1, 0, mk(6'b000001, 0, 24'hFF, 8'h01, 1, 16'h9), 8'h05, 0, 2'd0);
    issue("R8", MEM, 16'd0, 3'd0, 0, mk(6'b000001, 0, 24'hFF, 8'h01, 1, 16'h9), 8'h05, 0, 2'd0);
    issue("R8", MEM, 16'd4, 3'd0, 0, mk(6'b000001, 0, 24'hFFFFFF, 8'h01, 1, 16'h9), 8'h05, 0, 2'd0);
    // shadow: grant on thread 3, then a fault on thread 3 must not disturb it
    issue("R11", MEM, 16'd8, 3'd4, 0, mk(6'b010000, 0, 24'hFFFFFF, 8'h07, 1, 16'hBEEF), 8'h07, 1, 2'd3);
    issue("R11", MEM, 16'd8, 3'd4, 0, mk(6'b010000, 0, 24'hFFFFFF, 8'h07, 1, 16'hDEAD), 8'h08, 1, 2'd3);
    // held fault refuses a waiting request until acknowledged
    issue("R12", MEM, 16'd4, 3'd0, 0, mk(6'b0, 0, 24'hFFFFFF, 8'h05, 1, 16'h1), 8'h05, 1, 2'd1, 0);
    drive(MEM, 16'd4, 3'd0, 0, full, 8'h05, 1, 2'd1);
    req_valid = 1'b1;
    repeat (4) @(negedge clk);
    fault_ack = 1'b1;
    @(negedge clk);
    fault_ack = 1'b0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule